// File: doc/BRIEF.md
# TDM Time-Slot Router

This block sits between a TDM line framer and a set of five internal serial channels. Each frame is a sequence of byte-wide time slots. The block decides, slot by slot, which channel owns the slot. In the receive direction it hands the received byte to that channel. In the transmit direction it asks that channel for a byte and passes the byte back to the line. A slot can also belong to no channel.

Ownership is programmed as an ordered list of runs. Each run names a number of consecutive slots and a destination. The list is walked from its first run whenever a frame sync arrives. Receive and transmit each have their own list, their own frame sync and their own walker, so the two directions can be laid out and aligned differently.

Lists are written through a small address/data port. That port only takes effect while routing is disabled.

Top module: `tdm_slot_router`

## Requirements
- R1: A table entry is written at addresses 0 to 63 (cfg_addr_i bit 6 low) with data bits [5:0] = run length minus one (so 1 to 64 slots), bits [8:6] = destination code and bits [11:9] = flags. Any address with bit 6 high writes the entry count, with data bits [5:0] = number of entries minus one (1 to 64 entries). cfg_dir_i = 0 selects the receive table and 1 selects the transmit table.
- R2: An entry write with nonzero flags, or with a destination code above 5, leaves the table unchanged.
- R3: Configuration writes made while enable_i is high are ignored.
- R4: A receive slot strobe (rx_slot_vld_i) whose slot falls in a run with destination d from 1 to 5 raises rx_ch_vld_o bit d-1 alone one cycle later, with rx_ch_data_o equal to the slot byte. Runs are consumed in list order, starting at slot 0. Slot 0 is the strobe that carries rx_fs_i.
- R5: A slot whose run has destination 0 produces no channel strobe.
- R6: Slots beyond the end of the last entry are treated as destination 0 until the next frame sync.
- R7: A transmit slot request (tx_slot_req_i) with destination d from 1 to 5 raises tx_ch_req_o bit d-1 in the same cycle. One cycle later, tx_line_vld_o is high and tx_line_data_o holds the byte that channel presented on tx_ch_data_i bits [8d-1:8d-8] in the request cycle.
- R8: A transmit slot with destination 0, or past the end of the table, puts all ones on tx_line_data_o.
- R9: A frame sync restarts the walk at slot 0 of the first entry, even in the middle of a table.
- R10: The receive and transmit tables, frame syncs and slot positions are independent of each other.
- R11: While enable_i is low, no channel strobe, request or line byte is produced. Each walker returns to slot 0, so the first strobe after enabling counts as slot 0 even without a sync.
- R12: After reset, each table holds one entry of one unused slot, with a count of one entry, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Routing enable; configuration is locked while high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dir_i | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_addr_i | input | 7 | Entry index, or entry count when bit 6 is set |
| cfg_wdata_i | input | 12 | Entry word or count word |
| rx_fs_i | input | 1 | Receive frame sync, qualified by rx_slot_vld_i |
| rx_slot_vld_i | input | 1 | Receive slot byte strobe from framer |
| rx_slot_data_i | input | 8 | Received slot byte |
| rx_ch_vld_o | output | 5 | Per-channel receive byte strobe |
| rx_ch_data_o | output | 8 | Receive byte for the strobed channel |
| tx_fs_i | input | 1 | Transmit frame sync, qualified by tx_slot_req_i |
| tx_slot_req_i | input | 1 | Transmit slot byte request from framer |
| tx_ch_req_o | output | 5 | Per-channel transmit byte request |
| tx_ch_data_i | input | 40 | Transmit bytes, channel c at bits [8c+7:8c] |
| tx_line_vld_o | output | 1 | Transmit line byte valid |
| tx_line_data_o | output | 8 | Transmit line byte |

## Verification
The hardest cases to reach are the boundaries of the run walker. These are a run of the full 64 slots, a table of 64 one-slot entries, and the step from the last entry into the unused region. Each of these needs a full reprogramming pass before it can be seen. The stimulus reprograms both tables several times while disabled. It then runs frames longer than the table, inserts idle cycles between strobes, and issues syncs in mid-frame or offset between the two directions. A cycle-level behavioural model expands each table into slot ownership and predicts every output.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int unsigned MAX_ENT = 64;
  localparam int unsigned MAX_RUN = 64;
  localparam int unsigned N_CH    = 5;
  localparam int unsigned N_DIR   = 2;
  localparam int unsigned IDX_W   = $clog2(MAX_ENT);
  localparam int unsigned LEN_W   = $clog2(MAX_RUN);
  localparam int unsigned DST_W   = $clog2(N_CH + 1);
  localparam int unsigned FLG_W   = 3;
  localparam int unsigned ADR_W   = IDX_W + 1;
  localparam int unsigned WRD_W   = LEN_W + DST_W + FLG_W;

  typedef struct packed {
    logic [DST_W-1:0] dest;
    logic [LEN_W-1:0] len_m1;
  } run_t;
endpackage

// File: rtl/tsr_table.sv
module tsr_table
  import tsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] addr_i,
  input  logic [WRD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output run_t             rd_run_o,
  output logic [IDX_W-1:0] cnt_m1_o
);
  run_t             mem_q [MAX_ENT];
  logic [IDX_W-1:0] cnt_q;
  run_t             wr_run;
  logic             is_cnt;
  logic             ent_ok;

  assign wr_run = run_t'(wdata_i[LEN_W+DST_W-1:0]);
  assign is_cnt = addr_i[ADR_W-1];
  assign ent_ok = (wdata_i[WRD_W-1 -: FLG_W] == '0) && (wr_run.dest <= DST_W'(N_CH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_ENT; i++) mem_q[i] <= '0;
      cnt_q <= '0;
    end else if (we_i && !lock_i) begin
      if (is_cnt) cnt_q <= wdata_i[IDX_W-1:0];
      else if (ent_ok) mem_q[addr_i[IDX_W-1:0]] <= wr_run;
    end
  end

  assign rd_run_o = mem_q[rd_idx_i];
  assign cnt_m1_o = cnt_q;

  assert_cnt_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(cnt_q));
  assert_first_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(mem_q[0]));
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker
  import tsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             fs_i,
  input  run_t             run_i,
  input  logic [IDX_W-1:0] cnt_m1_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [DST_W-1:0] dest_o
);
  logic [IDX_W-1:0] idx_q, idx_d, eff_idx;
  logic [LEN_W-1:0] pos_q, pos_d, eff_pos;
  logic             done_q, done_d, eff_done;

  // a sync on this strobe makes it slot 0
  assign eff_idx  = fs_i ? '0 : idx_q;
  assign eff_pos  = fs_i ? '0 : pos_q;
  assign eff_done = fs_i ? 1'b0 : done_q;
  assign rd_idx_o = eff_idx;
  assign dest_o   = eff_done ? '0 : run_i.dest;

  always_comb begin
    idx_d  = eff_idx;
    pos_d  = eff_pos;
    done_d = eff_done;
    if (!eff_done) begin
      if (eff_pos == run_i.len_m1) begin
        pos_d = '0;
        if (eff_idx == cnt_m1_i) done_d = 1'b1;
        else idx_d = eff_idx + 1'b1;
      end else begin
        pos_d = eff_pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      idx_q  <= '0;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (stb_i) begin
      idx_q  <= idx_d;
      pos_q  <= pos_d;
      done_q <= done_d;
    end
  end

  assert_idx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> idx_q <= cnt_m1_i);
  assert_done_at_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_q) |-> idx_q == cnt_m1_i);
  assert_idle_rewind_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (idx_q == '0 && pos_q == '0 && !done_q));
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tsr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cfg_we_i,
  input  logic             cfg_dir_i,
  input  logic [ADR_W-1:0] cfg_addr_i,
  input  logic [WRD_W-1:0] cfg_wdata_i,
  input  logic             rx_fs_i,
  input  logic             rx_slot_vld_i,
  input  logic [DW-1:0]    rx_slot_data_i,
  output logic [N_CH-1:0]  rx_ch_vld_o,
  output logic [DW-1:0]    rx_ch_data_o,
  input  logic             tx_fs_i,
  input  logic             tx_slot_req_i,
  output logic [N_CH-1:0]  tx_ch_req_o,
  input  logic [N_CH*DW-1:0] tx_ch_data_i,
  output logic             tx_line_vld_o,
  output logic [DW-1:0]    tx_line_data_o
);
  localparam int unsigned RX = 0;
  localparam int unsigned TX = 1;

  logic             stb  [N_DIR];
  logic             fs   [N_DIR];
  run_t             run  [N_DIR];
  logic [IDX_W-1:0] cnt  [N_DIR];
  logic [IDX_W-1:0] ridx [N_DIR];
  logic [DST_W-1:0] dest [N_DIR];

  assign stb[RX] = rx_slot_vld_i;
  assign fs[RX]  = rx_fs_i;
  assign stb[TX] = tx_slot_req_i;
  assign fs[TX]  = tx_fs_i;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    tsr_table u_table (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lock_i   (enable_i),
      .we_i     (cfg_we_i && (cfg_dir_i == 1'(d))),
      .addr_i   (cfg_addr_i),
      .wdata_i  (cfg_wdata_i),
      .rd_idx_i (ridx[d]),
      .rd_run_o (run[d]),
      .cnt_m1_o (cnt[d])
    );
    tsr_walker u_walker (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (enable_i),
      .stb_i    (stb[d]),
      .fs_i     (fs[d]),
      .run_i    (run[d]),
      .cnt_m1_i (cnt[d]),
      .rd_idx_o (ridx[d]),
      .dest_o   (dest[d])
    );
  end

  logic [N_CH-1:0] rx_hit, tx_hit;
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign rx_hit[c] = enable_i && rx_slot_vld_i && (dest[RX] == DST_W'(c + 1));
    assign tx_hit[c] = enable_i && tx_slot_req_i && (dest[TX] == DST_W'(c + 1));
  end
  assign tx_ch_req_o = tx_hit;

  logic [DW-1:0] tx_sel;
  always_comb begin
    tx_sel = '1;
    for (int c = 0; c < N_CH; c++)
      if (tx_hit[c]) tx_sel = tx_ch_data_i[c*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ch_vld_o    <= '0;
      rx_ch_data_o   <= '0;
      tx_line_vld_o  <= 1'b0;
      tx_line_data_o <= '0;
    end else begin
      rx_ch_vld_o   <= rx_hit;
      tx_line_vld_o <= enable_i && tx_slot_req_i;
      if (enable_i && rx_slot_vld_i) rx_ch_data_o <= rx_slot_data_i;
      if (enable_i && tx_slot_req_i) tx_line_data_o <= tx_sel;
    end
  end

  assert_rx_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_ch_vld_o));
  assert_tx_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_ch_req_o));
  assert_rx_needs_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_ch_vld_o) |-> $past(rx_slot_vld_i));
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (rx_ch_vld_o == '0 && !tx_line_vld_o));
  assert_unused_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_line_vld_o && $past(tx_ch_req_o) == '0) |-> tx_line_data_o == '1);
endmodule

// File: tb/tb_tdm_slot_router.sv
`timescale 1ns/1ps
module tb_tdm_slot_router;
  import tsr_pkg::*;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic             enable_i = 0, cfg_we_i = 0, cfg_dir_i = 0;
  logic [6:0]       cfg_addr_i = '0;
  logic [11:0]      cfg_wdata_i = '0;
  logic             rx_fs_i = 0, rx_slot_vld_i = 0, tx_fs_i = 0, tx_slot_req_i = 0;
  logic [7:0]       rx_slot_data_i = '0;
  logic [4:0]       rx_ch_vld_o, tx_ch_req_o;
  logic [7:0]       rx_ch_data_o, tx_line_data_o;
  logic [39:0]      tx_ch_data_i = '0;
  logic             tx_line_vld_o;

  tdm_slot_router dut (.*);

  int checks = 0, bad = 0, cyc_n = 0;
  int m_len [2][64];
  int m_dst [2][64];
  int m_cnt [2];
  int m_slot [2];
  logic m_en = 0;

  function automatic int slot_dest(int d, int s);
    int acc = 0;
    for (int e = 0; e < m_cnt[d]; e++) begin
      if (s < acc + m_len[d][e]) return m_dst[d][e];
      acc += m_len[d][e];
    end
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic rs, logic rf, logic [7:0] rd, logic ts, logic tf, string ph);
    int rsl, tsl, rdst, tdst;
    logic [4:0] e_rv;
    logic [7:0] e_td;
    logic e_tv;
    string rt, tt;
    rx_slot_vld_i = rs; rx_fs_i = rf; rx_slot_data_i = rd;
    tx_slot_req_i = ts; tx_fs_i = tf;
    for (int c = 0; c < 5; c++) tx_ch_data_i[c*8 +: 8] = 8'((c + 1) * 16 + (cyc_n % 16));
    #1;
    rsl = rf ? 0 : m_slot[0];
    tsl = tf ? 0 : m_slot[1];
    rdst = (m_en && rs) ? slot_dest(0, rsl) : 0;
    tdst = (m_en && ts) ? slot_dest(1, tsl) : 0;
    rt = (rdst > 0) ? {ph, "/R4"} : (rdst < 0 ? {ph, "/R6"} : {ph, "/R5"});
    tt = (tdst > 0) ? {ph, "/R7"} : {ph, "/R8"};
    if (rdst < 0) rdst = 0;
    if (tdst < 0) tdst = 0;
    chk(tt, "tx_ch_req", 64'(tx_ch_req_o), (tdst > 0) ? 64'(1 << (tdst - 1)) : 64'd0);
    e_rv = (rdst > 0) ? 5'(1 << (rdst - 1)) : 5'd0;
    e_tv = m_en && ts;
    e_td = (tdst > 0) ? tx_ch_data_i[(tdst-1)*8 +: 8] : 8'hFF;
    if (!m_en) begin
      m_slot[0] = 0; m_slot[1] = 0;
    end else begin
      if (rs) m_slot[0] = rsl + 1;
      if (ts) m_slot[1] = tsl + 1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    cyc_n++;
    chk(rt, "rx_ch_vld", 64'(rx_ch_vld_o), 64'(e_rv));
    if (e_rv != 0) chk(rt, "rx_ch_data", 64'(rx_ch_data_o), 64'(rd));
    chk(tt, "tx_line_vld", 64'(tx_line_vld_o), 64'(e_tv));
    if (e_tv) chk(tt, "tx_line_data", 64'(tx_line_data_o), 64'(e_td));
  endtask

  task automatic cfg(logic dir, int addr, int data);
    cfg_we_i = 1; cfg_dir_i = dir; cfg_addr_i = 7'(addr); cfg_wdata_i = 12'(data);
    rx_slot_vld_i = 0; tx_slot_req_i = 0; rx_fs_i = 0; tx_fs_i = 0;
    @(posedge clk_i);
    if (!m_en) begin
      if (addr >= 64) m_cnt[dir] = (data & 63) + 1;
      else if (((data >> 9) & 7) == 0 && ((data >> 6) & 7) <= 5) begin
        m_len[dir][addr] = (data & 63) + 1;
        m_dst[dir][addr] = (data >> 6) & 7;
      end
      m_slot[0] = 0; m_slot[1] = 0;
    end
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic wr_ent(logic dir, int idx, int len, int dst, int flg);
    cfg(dir, idx, (len - 1) | (dst << 6) | (flg << 9));
  endtask

  task automatic wr_cnt(logic dir, int n);
    cfg(dir, 64, n - 1);
  endtask

  task automatic set_en(logic v);
    m_en = v; enable_i = v;
  endtask

  // both directions synced at slot 0, tx may sync later by toff
  task automatic frame(int n, int toff, int gap, string ph);
    for (int s = 0; s < n; s++) begin
      cyc(1'b1, s == 0, 8'(s * 7 + 3), 1'b1, s == toff, ph);
      if (gap > 0 && (s % gap) == gap - 1) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, ph);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_cnt[d] = 1; m_slot[d] = 0;
      for (int e = 0; e < 64; e++) begin m_len[d][e] = 1; m_dst[d][e] = 0; end
    end
    repeat (3) @(negedge clk_i);
    chk("R12", "rx_ch_vld", 64'(rx_ch_vld_o), 0);
    chk("R12", "tx_line_vld", 64'(tx_line_vld_o), 0);
    chk("R12", "tx_ch_req", 64'(tx_ch_req_o), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // reset tables: everything unused
    set_en(1);
    frame(4, 0, 0, "R12");

    // R10: different tables per direction
    set_en(0);
    cyc(0, 0, 0, 0, 0, "R10");
    wr_ent(0, 0, 2, 0, 0); wr_ent(0, 1, 24, 3, 0); wr_ent(0, 2, 1, 0, 0); wr_ent(0, 3, 5, 2, 0);
    wr_cnt(0, 4);
    wr_ent(1, 0, 3, 1, 0); wr_ent(1, 1, 1, 5, 0); wr_ent(1, 2, 4, 4, 0);
    wr_cnt(1, 3);
    set_en(1);
    frame(40, 0, 7, "R10");
    frame(36, 5, 0, "R10");

    // R9: sync in mid-frame
    frame(10, 0, 0, "R9");
    frame(30, 0, 4, "R9");

    // R3: writes while enabled are dropped
    wr_ent(0, 1, 1, 5, 0);
    wr_cnt(0, 1);
    wr_ent(1, 0, 2, 2, 0);
    frame(34, 0, 0, "R3");

    // R11: disable mid-frame rewinds the walkers
    frame(5, 0, 0, "R11");
    set_en(0);
    cyc(1, 0, 8'h55, 1, 0, "R11");
    cyc(1, 1, 8'h66, 1, 1, "R11");
    set_en(1);
    for (int s = 0; s < 12; s++) cyc(1, 0, 8'(s + 100), 1, 0, "R11");

    // R2: malformed entries rejected
    set_en(0);
    cyc(0, 0, 0, 0, 0, "R2");
    wr_ent(0, 0, 7, 1, 1);
    wr_ent(0, 1, 7, 6, 0);
    wr_ent(0, 2, 3, 7, 0);
    wr_ent(1, 1, 9, 2, 4);
    set_en(1);
    frame(36, 0, 0, "R2");

    // R1: longest run and longest table
    set_en(0);
    cyc(0, 0, 0, 0, 0, "R1");
    wr_ent(0, 0, 64, 5, 0);
    wr_cnt(0, 1);
    for (int e = 0; e < 64; e++) wr_ent(1, e, 1, e % 6, 0);
    wr_cnt(1, 64);
    set_en(1);
    frame(70, 0, 0, "R1");
    frame(66, 3, 9, "R1");

    set_en(0);
    cyc(1, 1, 8'h12, 1, 1, "R11");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule